// File: doc/BRIEF.md
# Keyed-Write Watchdog Interval Timer

This block is an 8-bit up-counting interval timer that sits on a small peripheral register port. A divider turns the input clock into count ticks. Its rate comes from a 3-bit select: select 0 gives a tick every 2 clocks, and select n gives a tick every 32·2ⁿ clocks. Counting runs only while an enable bit in the control byte is set. When the counter wraps from 0xFF to 0x00, the block sets a sticky flag. It also emits a one-cycle interrupt request together with a priority level and a vector number, both taken from two separate byte registers.

The control byte and the counter share one 16-bit write location. The upper byte of the write data is a key: it decides which of the two registers receives the lower byte. A write with any other key changes neither register. The priority and vector bytes have their own locations. All four bytes can be read back with a registered, one-cycle read port.

Top module: `keyed_interval_timer`

## Requirements
- R1: After synchronous reset, the control, counter, priority and vector bytes all read 0, and `irq_pulse` is low.
- R2: A write to location 0 with `wr_data[15:8]` = 0xA5 loads `wr_data[6:0]` into control bits 6..0. Control bits 2..0 are the rate select and bit 5 is the enable.
- R3: A write to location 0 whose upper byte is neither 0xA5 nor 0x5A leaves the control byte and the counter unchanged.
- R4: A write to location 0 with `wr_data[15:8]` = 0x5A loads `wr_data[7:0]` into the counter. This load takes precedence over a tick in the same cycle.
- R5: With rate select 0 the counter advances once every 2 clocks. With rate select n from 1 to 7 it advances once every 32·2ⁿ clocks.
- R6: The counter and the divider hold their values while control bit 5 is clear.
- R7: On a tick at count 0xFF the counter becomes 0x00 and `irq_pulse` is high for exactly the next cycle.
- R8: While `irq_pulse` is high, `irq_level` equals bits 7..4 of the priority byte and `irq_vector` equals bits 6..0 of the vector byte, both as they were at the wrap. Both outputs hold their values until the next wrap.
- R9: A wrap sets control bit 7. A keyed control write with data bit 7 clear clears bit 7. A keyed control write with data bit 7 set leaves bit 7 as it was.
- R10: A keyed control write restarts the divider from phase zero and produces no tick in that cycle, so the next tick comes a full period after the write.
- R11: The value of `rd_data` reflects the register selected by `rd_addr` one cycle earlier: 0 = control, 1 = counter, 2 = priority, 3 = vector. Writes to locations 2 and 3 load `wr_data[7:0]`. Writes to location 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write location |
| wr_data | input | 16 | Write data; the upper byte is the key at location 0 |
| rd_addr | input | 2 | Read location |
| rd_data | output | 8 | Registered read data |
| irq_pulse | output | 1 | One-cycle overflow interrupt request |
| irq_level | output | 4 | Priority level latched at the wrap |
| irq_vector | output | 7 | Vector number latched at the wrap |

## Verification
On every cycle, the assertions check the following:
- the divider phase never passes its period;
- the counter stays still without a tick or a load;
- an unkeyed write leaves the control byte alone;
- the interrupt lasts one cycle and comes with a zero counter and a set flag.

The exact tick spacing for each rate select, the phase restart after a control write, and the sticky-flag clearing rule can only be shown by the bench scenarios. The same holds for the level and vector values that come with each pulse. The bench checks these against its behavioural model on every clock and with fixed expected values.

// File: rtl/ktmr_pkg.sv
package ktmr_pkg;
  localparam logic [7:0] KEY_CTRL  = 8'hA5;
  localparam logic [7:0] KEY_COUNT = 8'h5A;
  localparam int EN_BIT   = 5;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    LOC_CTRL  = 2'd0,
    LOC_COUNT = 2'd1,
    LOC_PRIO  = 2'd2,
    LOC_VEC   = 2'd3
  } loc_e;
endpackage

// File: rtl/ktmr_regs.sv
module ktmr_regs
  import ktmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             flag_set,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       prio_q,
  output logic [7:0]       vec_q,
  output logic             ctrl_we,
  output logic             cnt_we,
  output logic [CNT_W-1:0] cnt_wdata,
  output logic [7:0]       rd_data
);
  logic at_timer;
  logic [7:0] rd_next;

  assign at_timer  = wr_en && (wr_addr == LOC_CTRL);
  assign ctrl_we   = at_timer && (wr_data[15:8] == KEY_CTRL);
  assign cnt_we    = at_timer && (wr_data[15:8] == KEY_COUNT);
  assign cnt_wdata = wr_data[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      prio_q <= '0;
      vec_q  <= '0;
    end else begin
      if (ctrl_we)
        ctrl_q <= {ctrl_q[FLAG_BIT] & wr_data[FLAG_BIT], wr_data[6:0]};
      else if (flag_set)
        ctrl_q[FLAG_BIT] <= 1'b1;
      if (wr_en && wr_addr == LOC_PRIO) prio_q <= wr_data[7:0];
      if (wr_en && wr_addr == LOC_VEC)  vec_q  <= wr_data[7:0];
    end
  end

  always_comb begin
    case (rd_addr)
      LOC_CTRL:  rd_next = ctrl_q;
      LOC_COUNT: rd_next = 8'(cnt_val);
      LOC_PRIO:  rd_next = prio_q;
      default:   rd_next = vec_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R3
  unkeyed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == LOC_CTRL && wr_data[15:8] != KEY_CTRL)
      |=> $stable(ctrl_q[6:0]));
endmodule

// File: rtl/ktmr_presc.sv
module ktmr_presc #(
  parameter int SEL_W      = 3,
  parameter int BASE_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PRE_W = BASE_SHIFT + (1 << SEL_W);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] last_val;

  always_comb begin
    if (sel == '0) last_val = PRE_W'(1);
    else           last_val = (PRE_W'(1) << (BASE_SHIFT + int'(sel))) - PRE_W'(1);
  end

  assign tick = enable && !restart && (phase_q == last_val);

  always_ff @(posedge clk) begin
    if (rst || restart) phase_q <= '0;
    else if (enable)    phase_q <= tick ? '0 : phase_q + PRE_W'(1);
  end

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q <= last_val);

  // R6
  phase_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/ktmr_count.sv
module ktmr_count #(
  parameter int CNT_W = 8,
  parameter int LVL_W = 4,
  parameter int VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic [VEC_W-1:0] vec_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             irq_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [VEC_W-1:0] vec_q
);
  assign wrap = tick && !load && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      irq_q <= wrap;
      if (load)      cnt_q <= load_val;
      else if (tick) cnt_q <= cnt_q + CNT_W'(1);
      if (wrap) begin
        lvl_q <= lvl_in;
        vec_q <= vec_in;
      end
    end
  end

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);

  // R7
  irq_zero_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (cnt_q == '0));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));

  // R8
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_q |-> $stable(vec_q));
endmodule

// File: rtl/keyed_interval_timer.sv
module keyed_interval_timer
  import ktmr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 3,
  parameter int BASE_SHIFT = 5,
  parameter int LVL_W      = 4,
  parameter int VEC_W      = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [15:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             irq_pulse,
  output logic [LVL_W-1:0] irq_level,
  output logic [VEC_W-1:0] irq_vector
);
  logic [7:0]       ctrl_q, prio_q, vec_q;
  logic             ctrl_we, cnt_we, tick, wrap;
  logic [CNT_W-1:0] cnt_wdata, cnt_q;

  ktmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .flag_set(wrap), .cnt_val(cnt_q),
    .ctrl_q(ctrl_q), .prio_q(prio_q), .vec_q(vec_q),
    .ctrl_we(ctrl_we), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .rd_data(rd_data)
  );

  ktmr_presc #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_presc (
    .clk(clk), .rst(rst), .enable(ctrl_q[EN_BIT]), .restart(ctrl_we),
    .sel(ctrl_q[SEL_W-1:0]), .tick(tick)
  );

  ktmr_count #(.CNT_W(CNT_W), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_we), .load_val(cnt_wdata),
    .lvl_in(prio_q[7 -: LVL_W]), .vec_in(vec_q[VEC_W-1:0]),
    .cnt_q(cnt_q), .wrap(wrap), .irq_q(irq_pulse),
    .lvl_q(irq_level), .vec_q(irq_vector)
  );

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> ctrl_q[FLAG_BIT]);

  // R10
  restart_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> !irq_pulse);
endmodule

// File: tb/keyed_interval_timer_bench.sv
module keyed_interval_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [7:0]  rd_data;
  logic        irq_pulse;
  logic [3:0]  irq_level;
  logic [6:0]  irq_vector;

  int n_chk = 0, n_fail = 0;
  int irq_seen = 0, seen_lvl = 0, seen_vec = 0;

  // behavioural reference state
  int m_ctrl = 0, m_cnt = 0, m_prio = 0, m_vec = 0, m_phase = 0;
  int m_rd = 0, m_rdsel = 0, m_lvl = 0, m_vout = 0, m_per = 2;
  bit m_irq = 0, m_valid = 0, m_cw = 0, m_nw = 0, m_tk = 0;

  always #4 clk = ~clk;

  keyed_interval_timer u_keyed_interval_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_cnt = 0; m_prio = 0; m_vec = 0; m_phase = 0;
      m_irq = 0; m_lvl = 0; m_vout = 0; m_rd = 0; m_rdsel = 0; m_valid = 1;
    end else begin
      m_rdsel = int'(rd_addr);
      case (rd_addr)
        2'd0: m_rd = m_ctrl;
        2'd1: m_rd = m_cnt;
        2'd2: m_rd = m_prio;
        default: m_rd = m_vec;
      endcase
      m_per = ((m_ctrl & 7) == 0) ? 2 : (32 << (m_ctrl & 7));
      m_cw = wr_en && wr_addr == 2'd0 && wr_data[15:8] == 8'hA5;
      m_nw = wr_en && wr_addr == 2'd0 && wr_data[15:8] == 8'h5A;
      m_tk = 0;
      if (m_cw) m_phase = 0;
      else if ((m_ctrl & 32) != 0) begin
        m_phase++;
        if (m_phase == m_per) begin m_phase = 0; m_tk = 1; end
      end
      m_irq = 0;
      if (m_nw) m_cnt = int'(wr_data[7:0]);
      else if (m_tk) begin
        if (m_cnt == 255) begin
          m_cnt = 0; m_irq = 1; m_ctrl = m_ctrl | 128;
          m_lvl = m_prio >> 4; m_vout = m_vec & 127;
        end else m_cnt++;
      end
      if (m_cw) m_ctrl = (m_ctrl & int'(wr_data[7:0]) & 128) | (int'(wr_data[7:0]) & 127);
      if (wr_en && wr_addr == 2'd2) m_prio = int'(wr_data[7:0]);
      if (wr_en && wr_addr == 2'd3) m_vec  = int'(wr_data[7:0]);
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_valid && !rst) begin
      chk("R7 irq_pulse", int'(irq_pulse), int'(m_irq));
      chk("R11 rd_data", int'(rd_data), m_rd);
      if (m_irq) begin
        chk("R8 irq_level", int'(irq_level), m_lvl);
        chk("R8 irq_vector", int'(irq_vector), m_vout);
      end
      if (irq_pulse) begin
        irq_seen++; seen_lvl = int'(irq_level); seen_vec = int'(irq_vector);
      end
    end
    rd_addr <= rd_addr + 2'd1;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input int sel, input int exp, input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      if (m_rdsel == sel) break;
    end
    chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", int'(irq_pulse), 0);
    peek(0, 8'h00, "R1 ctrl reset");
    peek(1, 8'h00, "R1 counter reset");
    peek(2, 8'h00, "R1 prio reset");
    // R3 unkeyed write
    wr(2'd0, 16'h1234);
    peek(0, 8'h00, "R3 ctrl after unkeyed write");
    peek(1, 8'h00, "R3 counter after unkeyed write");
    // R11 priority and vector bytes
    wr(2'd2, 16'h009C);
    wr(2'd3, 16'h00D5);
    peek(2, 8'h9C, "R11 prio readback");
    peek(3, 8'hD5, "R11 vector readback");
    // R4 counter load, R2 control load, R5 rate 0, R7/R8 overflow
    wr(2'd0, 16'h5AFD);
    peek(1, 8'hFD, "R4 counter load");
    base = irq_seen;
    wr(2'd0, 16'hA520);
    repeat (10) @(negedge clk);
    chk("R7 one overflow at rate 0", irq_seen - base, 1);
    chk("R8 level from prio upper nibble", seen_lvl, 9);
    chk("R8 vector low 7 bits", seen_vec, 8'h55);
    peek(0, 8'hA0, "R9 flag set by wrap, R2 ctrl bits");
    // R9 flag clearing rule
    wr(2'd0, 16'hA5A0);
    peek(0, 8'hA0, "R9 flag kept by data bit 7 set");
    wr(2'd0, 16'hA500);
    peek(0, 8'h00, "R9 flag cleared by data bit 7 clear");
    // R5 rate 1: one tick every 64 clocks
    wr(2'd0, 16'h5A10);
    wr(2'd0, 16'hA521);
    repeat (200) @(negedge clk);
    wr(2'd0, 16'hA501);
    peek(1, 8'h13, "R5 three ticks in 201 clocks at rate 1");
    // R6 disabled timer holds
    repeat (300) @(negedge clk);
    peek(1, 8'h13, "R6 counter frozen while disabled");
    // R11 write to counter location ignored
    wr(2'd1, 16'h5A77);
    peek(1, 8'h13, "R11 write at location 1 ignored");
    // R10 phase restart
    wr(2'd0, 16'h5A00);
    wr(2'd0, 16'hA521);
    repeat (50) @(negedge clk);
    wr(2'd0, 16'hA521);
    repeat (50) @(negedge clk);
    peek(1, 8'h00, "R10 no tick before full period after restart");
    repeat (20) @(negedge clk);
    peek(1, 8'h01, "R10 tick one period after restart");
    // R5 rate 7: 4096 clocks per tick
    wr(2'd0, 16'h5AFF);
    base = irq_seen;
    wr(2'd0, 16'hA527);
    repeat (4090) @(negedge clk);
    chk("R5 no wrap before 4096 clocks at rate 7", irq_seen - base, 0);
    repeat (20) @(negedge clk);
    chk("R5 wrap after 4096 clocks at rate 7", irq_seen - base, 1);
    wr(2'd0, 16'hA500);
    peek(0, 8'h00, "R2 disabled and flag cleared");
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule